// File: doc/BRIEF.md
# Oversampled Strobe Link Receiver

This block takes byte-wide data from a front-end digitizer over a parallel link whose clock, valid flag and data are all driven by the sender. The receiver never uses the link clock as a clock. It runs entirely on its own faster system clock, samples the link clock as an ordinary input and finds its edges there. On each selected edge it captures the byte, provided the valid flag is high, and issues a one-cycle write strobe with that byte to a local FIFO. The FIFO sits outside this block.

Flow control back to the sender is a single enable line. The receiver drops enable once the FIFO occupancy reaches a high threshold. It raises enable again only after the occupancy has fallen below a lower threshold, which gives hysteresis. Dropping enable does not stop capture: every word the sender presents with valid high is still written, until the sender lowers valid. The high threshold therefore leaves room for those in-flight words. If a word arrives while the FIFO reports full occupancy, that word is discarded and a sticky overflow flag is raised.

Top module: `strobe_link_rx`

## Requirements
- R1: While reset is asserted and on the first cycles after its release, `lnk_enable` is 1 and both `wr_en` and `ovf_flag` are 0.
- R2: Each rising edge of `lnk_clk` seen while `lnk_valid` is 1 produces exactly one write. That write carries the byte held on `lnk_data` around the edge. Words appear in the order they were sent.
- R3: A rising edge of `lnk_clk` seen while `lnk_valid` is 0 produces no write. A falling edge of `lnk_clk` never produces a write.
- R4: While `lnk_enable` is 1, an occupancy on `fifo_level` at or above HI_TH (default 56) makes `lnk_enable` 0 on the next system clock edge.
- R5: While `lnk_enable` is 0, it stays 0 for any occupancy at or above LO_TH (default 32). It returns to 1 on the next system clock edge once the occupancy is below LO_TH.
- R6: A word sent with `lnk_valid` at 1 is written even while `lnk_enable` is 0.
- R7: A word that arrives while `fifo_level` is at or above DEPTH (default 64) is not written and sets `ovf_flag` to 1. `ovf_flag` then stays 1 until reset, whatever the occupancy does.
- R8: `wr_en` is never high on two consecutive system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lnk_clk | input | 1 | Link clock from the sender, treated as sampled data |
| lnk_valid | input | 1 | Sender's word-valid flag |
| lnk_data | input | 8 | Sender's data byte |
| fifo_level | input | 7 | Current FIFO occupancy in words (0 to DEPTH) |
| lnk_enable | output | 1 | Flow-control enable returned to the sender |
| wr_en | output | 1 | One-cycle FIFO write strobe |
| wr_data | output | 8 | Byte written to the FIFO with `wr_en` |
| ovf_flag | output | 1 | Sticky flag: a word arrived while the FIFO was full |

## Verification
A wrong edge-detector history shows at the ports as a missing or doubled write strobe within three system cycles of a link clock transition. The scoreboard catches it as an extra item, a missing item or a mismatched byte. A wrong enable state stays visible on `lnk_enable` from the cycle after the occupancy crosses a threshold. Stepping the occupancy through both thresholds in each direction exposes a lost hysteresis bit within one cycle. A lost sticky bit shows on `ovf_flag` as soon as the occupancy drops back below full.

// File: rtl/strobe_rx_pkg.sv
package strobe_rx_pkg;
  localparam int LINK_DW = 8;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  typedef struct packed {
    logic               clk;
    logic               vld;
    logic [LINK_DW-1:0] data;
  } link_smp_t;

  localparam int SMP_W = $bits(link_smp_t);
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sync_pipe.sv
module sync_pipe #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = din;
      end else begin : g_rest
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/edge_detect.sv
module edge_detect
  import strobe_rx_pkg::*;
#(
  parameter edge_sel_e SEL = EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  output logic strobe
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  generate
    if (SEL == EDGE_FALL) begin : g_fall
      assign strobe = prev_q & ~smp;
    end else begin : g_rise
      assign strobe = smp & ~prev_q;
    end
  endgenerate

  // R8
  strobe_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/credit_ctrl.sv
module credit_ctrl #(
  parameter int DEPTH = 64,
  parameter int HI_TH = 56,
  parameter int LO_TH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             word_in,
  output logic             enable,
  output logic             full,
  output logic             ovf
);
  localparam logic [LVL_W-1:0] HI_LVL   = LVL_W'(HI_TH);
  localparam logic [LVL_W-1:0] LO_LVL   = LVL_W'(LO_TH);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic en_q, en_d, en_ce;
  logic ovf_q, ovf_d, ovf_ce;

  assign full = (level >= FULL_LVL);

  always_comb begin
    en_ce = 1'b0;
    en_d  = en_q;
    if (en_q && (level >= HI_LVL)) begin
      en_ce = 1'b1;
      en_d  = 1'b0;
    end else if (!en_q && (level < LO_LVL)) begin
      en_ce = 1'b1;
      en_d  = 1'b1;
    end
  end

  always_comb begin
    ovf_ce = word_in & full & ~ovf_q;
    ovf_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b1;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (ovf_ce) ovf_q <= ovf_d;
  end

  assign enable = en_q;
  assign ovf    = ovf_q;

  // R4
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && level >= HI_LVL) |=> !enable);
  // R5
  en_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && level >= LO_LVL) |=> !enable);
  // R5
  en_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && level < LO_LVL) |=> enable);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_in && full) |=> ovf);
endmodule

// File: rtl/strobe_link_rx.sv
module strobe_link_rx
  import strobe_rx_pkg::*;
#(
  parameter int        DEPTH       = 64,
  parameter int        HI_TH       = 56,
  parameter int        LO_TH       = 32,
  parameter int        SYNC_STAGES = 2,
  parameter edge_sel_e CAP_EDGE    = EDGE_RISE,
  localparam int       LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lnk_clk,
  input  logic               lnk_valid,
  input  logic [LINK_DW-1:0] lnk_data,
  input  logic [LVL_W-1:0]   fifo_level,
  output logic               lnk_enable,
  output logic               wr_en,
  output logic [LINK_DW-1:0] wr_data,
  output logic               ovf_flag
);
  logic      rst_ns;
  link_smp_t raw_smp, sync_smp;
  logic      cap_stb, word_in, fifo_full;

  rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  assign raw_smp = '{clk: lnk_clk, vld: lnk_valid, data: lnk_data};

  sync_pipe #(.W(SMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .din(raw_smp), .dout(sync_smp)
  );

  edge_detect #(.SEL(CAP_EDGE)) u_edge (
    .clk(clk), .rst_n(rst_ns), .smp(sync_smp.clk), .strobe(cap_stb)
  );

  assign word_in = cap_stb & sync_smp.vld;

  credit_ctrl #(.DEPTH(DEPTH), .HI_TH(HI_TH), .LO_TH(LO_TH), .LVL_W(LVL_W)) u_credit (
    .clk(clk), .rst_n(rst_ns), .level(fifo_level), .word_in(word_in),
    .enable(lnk_enable), .full(fifo_full), .ovf(ovf_flag)
  );

  logic               wr_q, wr_d;
  logic [LINK_DW-1:0] data_q, data_d;
  logic               data_ce;

  always_comb begin
    wr_d    = word_in & ~fifo_full;
    data_ce = wr_d;
    data_d  = sync_smp.data;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) wr_q <= 1'b0;
    else         wr_q <= wr_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)       data_q <= '0;
    else if (data_ce)  data_q <= data_d;
  end

  assign wr_en   = wr_q;
  assign wr_data = data_q;

  // R8
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_en |=> !wr_en);
  // R7
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (word_in && fifo_full) |=> !wr_en);
  // R3
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !word_in |=> !wr_en);
endmodule

// File: tb/strobe_link_rx_tb_top.sv
module strobe_link_rx_tb_top;
  localparam int DEPTH = 64;
  localparam int HI_TH = 56;
  localparam int LO_TH = 32;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lnk_clk = 1'b0;
  logic             lnk_valid = 1'b0;
  logic [7:0]       lnk_data = 8'h00;
  logic [LVL_W-1:0] fifo_level = '0;
  logic             lnk_enable, wr_en, ovf_flag;
  logic [7:0]       wr_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  bit prev_wr = 1'b0;
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  strobe_link_rx #(.DEPTH(DEPTH), .HI_TH(HI_TH), .LO_TH(LO_TH)) dut_i (
    .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_valid(lnk_valid),
    .lnk_data(lnk_data), .fifo_level(fifo_level), .lnk_enable(lnk_enable),
    .wr_en(wr_en), .wr_data(wr_data), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [7:0] d, input logic v);
    @(negedge clk);
    lnk_data  = d;
    lnk_valid = v;
    repeat (2) @(negedge clk);
    lnk_clk = 1'b1;
    if (v && fifo_level < LVL_W'(DEPTH)) exp_q.push_back(d);
    repeat (4) @(negedge clk);
    lnk_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          check("R3 unexpected write", 1, 0);
        end else begin
          check("R2 write data", int'(wr_data), int'(exp_q.pop_front()));
        end
      end
      if (prev_wr) check("R8 single-cycle write", int'(wr_en), 0);
      prev_wr = wr_en;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 enable in reset", int'(lnk_enable), 1);
    check("R1 wr_en in reset", int'(wr_en), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 enable after reset", int'(lnk_enable), 1);
    check("R1 ovf after reset", int'(ovf_flag), 0);
    check("R1 wr_en after reset", int'(wr_en), 0);
    mon_on = 1'b1;

    // R2: several data patterns
    send_word(8'hA5, 1'b1);
    send_word(8'h5A, 1'b1);
    send_word(8'h00, 1'b1);
    send_word(8'hFF, 1'b1);
    send_word(8'h3C, 1'b1);
    // R3: valid low
    send_word(8'h77, 1'b0);
    send_word(8'h81, 1'b1);
    check("R2 queue drained", exp_q.size(), 0);

    // R4 thresholds
    fifo_level = LVL_W'(HI_TH - 1);
    @(negedge clk);
    check("R4 below high keeps enable", int'(lnk_enable), 1);
    fifo_level = LVL_W'(HI_TH);
    @(negedge clk);
    check("R4 at high drops enable", int'(lnk_enable), 0);
    // R6: accepted while enable low
    send_word(8'hC3, 1'b1);
    send_word(8'h19, 1'b1);
    check("R6 words written with enable low", exp_q.size(), 0);
    // R5 hysteresis
    fifo_level = LVL_W'(LO_TH + 5);
    @(negedge clk);
    check("R5 between thresholds stays low", int'(lnk_enable), 0);
    fifo_level = LVL_W'(LO_TH);
    @(negedge clk);
    check("R5 at low threshold stays low", int'(lnk_enable), 0);
    fifo_level = LVL_W'(LO_TH - 1);
    @(negedge clk);
    check("R5 below low resumes", int'(lnk_enable), 1);
    fifo_level = LVL_W'(LO_TH + 5);
    @(negedge clk);
    check("R5 rising inside band keeps enable", int'(lnk_enable), 1);

    // R7 overflow
    check("R7 ovf clear before full", int'(ovf_flag), 0);
    fifo_level = LVL_W'(DEPTH);
    send_word(8'hEE, 1'b1);
    check("R7 ovf set on full", int'(ovf_flag), 1);
    fifo_level = LVL_W'(0);
    repeat (3) @(negedge clk);
    check("R7 ovf sticky", int'(ovf_flag), 1);
    send_word(8'h42, 1'b1);
    check("R7 writes resume after full", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule